// File: doc/BRIEF.md
# Cascaded Synchronous BCD Decade Counter

This block is a multi-digit decimal counter made of identical four-bit decade stages that all run from one clock. Each stage holds one BCD digit and counts 0 to 9, then returns to 0 on its own. A stage takes a step only when both of its count enables are high: a parallel enable and a trickle enable. When a stage holds 9 and its trickle enable is high, it raises its terminal count.

The digits are linked by a lookahead chain. The least significant digit has both enables tied high, so it counts on every clock. Every higher digit takes its parallel enable from the terminal count of the first digit. It takes its trickle enable from the terminal count of the digit just below it. A higher digit is therefore enabled for exactly one clock period in each cycle of the digit below it, and no stage is ever clocked by another stage.

An active-low asynchronous reset clears all digits together. The number of digits is a parameter. The final terminal count is brought out as a carry.

Top module: `bcd_cascade_counter`

## Requirements
- R1: While rst_ni is low, every digit of count_o reads 0 and carry_o is 0. The clear takes effect without waiting for a clock edge.
- R2: With reset inactive, the least significant digit (count_o[3:0]) steps by one on every rising clock edge and goes from 9 back to 0.
- R3: Every four-bit field count_o[4k+3:4k] always holds a value from 0 to 9.
- R4: Digit k (k ≥ 1) steps by one, with 9 going to 0, on exactly those edges where all lower digits read 9. On every other edge it holds its value.
- R5: carry_o is 1 exactly when every digit reads 9, and 0 at all other times.
- R6: After 10^NUM_DIGITS - 1 the counter wraps to all zeros on the next edge, with no reset applied. count_o always equals the number of edges since reset, modulo 10^NUM_DIGITS, with digit k in bits [4k+3:4k].
- R7: When reset is applied in the middle of a count and then released, counting starts again from 0. The first edge after release gives a value of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Common clock for all stages |
| rst_ni | input | 1 | Asynchronous active-low clear of all digits |
| count_o | output | 4*NUM_DIGITS | Concatenated BCD digits, least significant digit in bits [3:0] |
| carry_o | output | 1 | Terminal count of the last stage; high when all digits are 9 |

## Verification
Each digit is a register that steps at the rising edge. Every count and carry result is therefore due one edge after the edge that caused it. The bench advances its reference count at each rising edge and compares at the following falling edge. The reset clear is asynchronous, so the bench lowers rst_ni halfway between edges and checks the zeros shortly afterwards, before any edge arrives. It releases reset on a falling edge, so the first counted edge is known for certain. Carry and the wrap are checked at the cycles where the reference count reaches its maximum and then returns to zero.

// File: rtl/bcd_cascade_pkg.sv
package bcd_cascade_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;
  localparam bcd_t BCD_MAX = bcd_t'(9);

  function automatic bcd_t bcd_next(bcd_t d);
    return (d == BCD_MAX) ? bcd_t'(0) : bcd_t'(d + bcd_t'(1));
  endfunction
endpackage

// File: rtl/bcd_decade_stage.sv
module bcd_decade_stage
  import bcd_cascade_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_par_i,
  input  logic en_tri_i,
  output bcd_t digit_o,
  output logic full_o,
  output logic tc_o
);
  bcd_t digit_q, digit_d;
  logic step;

  assign step   = en_par_i & en_tri_i;
  assign full_o = (digit_q == BCD_MAX);
  // gated by trickle enable so an upper 9 does not flag early
  assign tc_o   = en_tri_i & full_o;

  always_comb begin
    digit_d = digit_q;
    if (step) digit_d = bcd_next(digit_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) digit_q <= '0;
    else         digit_q <= digit_d;
  end

  assign digit_o = digit_q;
endmodule

// File: rtl/bcd_cascade_enables.sv
module bcd_cascade_enables #(
  parameter int unsigned NUM_DIGITS = 3
) (
  input  logic [NUM_DIGITS-1:0] full_i,
  output logic [NUM_DIGITS-1:0] en_par_o,
  output logic [NUM_DIGITS-1:0] en_tri_o
);
  // trickle enable of stage k = all lower stages at 9 (prefix AND)
  always_comb begin
    logic run;
    run = 1'b1;
    for (int k = 0; k < NUM_DIGITS; k++) begin
      en_tri_o[k] = run;
      run = run & full_i[k];
    end
  end

  // parallel enable: stage 0 tied high, others driven by stage 0 terminal count
  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_par
    if (k == 0) begin : g_lsd
      assign en_par_o[k] = 1'b1;
    end else begin : g_upper
      assign en_par_o[k] = full_i[0];
    end
  end
endmodule

// File: rtl/bcd_cascade_counter.sv
module bcd_cascade_counter
  import bcd_cascade_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 3,
  localparam int unsigned CNT_W = NUM_DIGITS * DIGIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] count_o,
  output logic             carry_o
);
  logic [NUM_DIGITS-1:0] full, en_par, en_tri, tc;
  logic                  unused_tc;

  bcd_cascade_enables #(.NUM_DIGITS(NUM_DIGITS)) u_enables (
    .full_i  (full),
    .en_par_o(en_par),
    .en_tri_o(en_tri)
  );

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_stage
    bcd_decade_stage u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_par_i(en_par[k]),
      .en_tri_i(en_tri[k]),
      .digit_o (count_o[k*DIGIT_W +: DIGIT_W]),
      .full_o  (full[k]),
      .tc_o    (tc[k])
    );
  end

  assign carry_o   = tc[NUM_DIGITS-1];
  assign unused_tc = ^tc;
endmodule

// File: rtl/bcd_cascade_chk.sv
module bcd_cascade_chk
  import bcd_cascade_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 3,
  localparam int unsigned CNT_W = NUM_DIGITS * DIGIT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_i,
  input logic             carry_i
);
  logic [NUM_DIGITS-1:0] is9;
  logic [NUM_DIGITS:0]   low9;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_is9
    assign is9[k] = (count_i[k*DIGIT_W +: DIGIT_W] == BCD_MAX);
  end

  assign low9[0] = 1'b1;
  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_low9
    assign low9[k+1] = low9[k] & is9[k];
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (count_i == '0 && !carry_i)
        else $error("R1: outputs not cleared in reset");
    end
  end

  p_lsd_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> count_i[DIGIT_W-1:0] == bcd_next($past(count_i[DIGIT_W-1:0])));

  p_carry_all9_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_i == low9[NUM_DIGITS]);

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    p_bcd_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_i[k*DIGIT_W +: DIGIT_W] <= BCD_MAX);

    if (k > 0) begin : g_upper
      p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low9[k] |=> count_i[k*DIGIT_W +: DIGIT_W]
                    == bcd_next($past(count_i[k*DIGIT_W +: DIGIT_W])));
      p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !low9[k] |=> $stable(count_i[k*DIGIT_W +: DIGIT_W]));
    end
  end
endmodule

bind bcd_cascade_counter bcd_cascade_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .count_i(count_o),
  .carry_i(carry_o)
);

// File: tb/tb_bcd_cascade_counter.sv
module tb_bcd_cascade_counter;
  localparam int N     = 3;
  localparam int W     = 4 * N;
  localparam int MOD   = 1000;
  localparam time TCLK = 8ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] count;
  logic         carry;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;

  bcd_cascade_counter #(.NUM_DIGITS(N)) dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .count_o(count),
    .carry_o(carry)
  );

  always #(TCLK/2) clk = ~clk;

  function automatic logic [W-1:0] to_bcd(int v);
    logic [W-1:0] r;
    int p;
    p = 1;
    for (int i = 0; i < N; i++) begin
      r[4*i +: 4] = 4'((v / p) % 10);
      p = p * 10;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic check_all();
    logic [W-1:0] e;
    e = to_bcd(exp_cnt);
    chk("R2", 32'(count[3:0]), 32'(e[3:0]));
    chk("R4", 32'(count[W-1:4]), 32'(e[W-1:4]));
    chk("R5", 32'(carry), 32'(exp_cnt == MOD - 1));
    for (int k = 0; k < N; k++)
      chk("R3", 32'(count[4*k +: 4] <= 4'd9), 32'd1);
  endtask

  task automatic step_and_check(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      exp_cnt = (exp_cnt + 1) % MOD;
      @(negedge clk);
      check_all();
    end
  endtask

  // R1: reset state
  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", 32'(count), 32'd0);
    chk("R1", 32'(carry), 32'd0);
    rst_n = 1'b1;
    exp_cnt = 0;
  endtask

  // R2, R4: count through several digit rollovers
  task automatic t_count_rollovers();
    step_and_check(125);
  endtask

  // R5, R6: run to full scale and wrap
  task automatic t_full_wrap();
    step_and_check(MOD - 1 - exp_cnt - 1);
    step_and_check(1);
    chk("R6", 32'(count), 32'(to_bcd(MOD - 1)));
    chk("R5", 32'(carry), 32'd1);
    step_and_check(1);
    chk("R6", 32'(count), 32'd0);
    chk("R5", 32'(carry), 32'd0);
    step_and_check(15);
  endtask

  // R1, R7: asynchronous reset mid-count, restart from zero
  task automatic t_reset_mid();
    step_and_check(47);
    @(negedge clk);
    #(TCLK/8);
    rst_n = 1'b0;
    #(TCLK/8);
    chk("R1", 32'(count), 32'd0);
    chk("R1", 32'(carry), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_cnt = 0;
    @(posedge clk);
    exp_cnt = 1;
    @(negedge clk);
    chk("R7", 32'(count), 32'(to_bcd(1)));
    step_and_check(12);
  endtask

  initial begin
    #(TCLK * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_count_rollovers();
    t_full_wrap();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule